// File: doc/BRIEF.md
# Parallel Pin Port with Edge-Capture Interrupt

A memory-mapped general-purpose pin port for a simple single-beat slave bus. Software reaches four 32-bit registers through a strobe, a write-enable and a register index. The registers are the pin data, a per-pin drive-direction mask, an interrupt mask and a sticky edge-capture register. A parameter fixes how the pins appear at the block edge. The choices are input-only, output-only, separate input and output buses, or one shared bidirectional bus in which every pin either drives or listens according to its own direction bit.

Input pins pass through a two-flop synchroniser before any use. A rising edge on a synchronised input pin sets its bit in the capture register, and the bit stays set until software clears it by writing a 1 to it. A single active-high interrupt line is raised while any captured bit is also enabled in the mask. A transfer opens when the strobe is seen high and is acknowledged once, one clock later. The master must drop the strobe before it starts the next transfer. There is no other flow control: the port never stalls a transfer.

Top module: `pio_edge_port`

## Requirements
- R1: `bus_reg` selects a register: 0 selects pin data, 1 selects drive direction, 2 selects interrupt mask and 3 selects edge capture. Bit n of each register belongs to pin n, and byte lane k holds bits [8k+7:8k].
- R2: `bus_ack` goes high for exactly one clock, in the cycle after `bus_stb` is first sampled high. It stays low while the strobe is held and rises again only after the strobe has been low. A write takes effect at the same clock edge that raises the acknowledge.
- R3: `bus_rdat` carries the selected register while `bus_ack` is high during a read, and reads 0 at all other times. `bus_ack`, `bus_rdat` and `irq` are 0 after reset.
- R4: In shared-bus mode, pin n is driven with data bit n when direction bit n is 1 and is released when the bit is 0. All registers reset to 0, so every pin starts as an input with all interrupts masked.
- R5: A read of the data register returns the synchronised pin levels. A change at a pin becomes readable two clocks later. In shared-bus mode a pin that drives reads back its own driven level.
- R6: A rising edge on the synchronised level of an input pin (direction bit 0) sets its capture bit, which can be read three clocks after the pin change. A falling edge, or any edge on a pin that drives, sets nothing.
- R7: A capture bit stays set until a write of 1 to it. Writing 0 to a capture bit has no effect. If a new edge arrives in the same clock as the clear, the new edge wins.
- R8: `irq` is high exactly when some bit is set in both the capture register and the mask register.
- R9: In separate-bus mode, `pin_out` follows the data register and a read of the data register returns the synchronised `pin_in`.
- R10: Register bits above the configured pin count read as 0, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | Transfer strobe, high while a transfer is requested |
| bus_we | input | 1 | 1 requests a write, 0 requests a read |
| bus_reg | input | 2 | Register index (byte offset divided by four) |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-clock transfer completion |
| pin_in | input | IN_W | Input pins (input-only and separate-bus modes) |
| pin_out | output | OUT_W | Output pins (output-only and separate-bus modes) |
| pin_io | inout | IO_W | Shared bidirectional pins (shared-bus mode) |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The assertions assume that the master keeps `bus_we`, `bus_reg` and `bus_wdat` stable while the strobe is high. They also assume that each strobe is dropped after its acknowledge and before the next transfer begins. The bench drives each transfer through one task that raises the strobe, waits for the acknowledge and lowers it, so it never runs two transfers back to back. On the shared pins, the bench drives only the pins whose direction bit is 0 in its own model, which avoids contention while the port is settled. Every pin change and every register write is followed by three quiet clocks, so each capture completes before the next access.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PIO_IN_ONLY  = 2'd0,
    PIO_OUT_ONLY = 2'd1,
    PIO_IN_OUT   = 2'd2,
    PIO_TRISTATE = 2'd3
  } pio_mode_e;

  localparam int REG_W  = 32;
  localparam int N_REGS = 4;
  localparam int IDX_W  = $clog2(N_REGS);

  localparam logic [IDX_W-1:0] IDX_DATA = 2'd0;
  localparam logic [IDX_W-1:0] IDX_DIR  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_MASK = 2'd2;
  localparam logic [IDX_W-1:0] IDX_CAP  = 2'd3;

  function automatic logic [REG_W-1:0] low_mask(input int n);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/pio_bus_port.sv
module pio_bus_port #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int AW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb,
  input  logic                     we,
  input  logic [AW-1:0]            idx,
  input  logic [NREG-1:0][DW-1:0]  rd_regs,
  output logic                     ack,
  output logic [DW-1:0]            rdat,
  output logic [NREG-1:0]          wr_en
);
  logic done_q, ack_q, go;
  logic [DW-1:0] rdat_q;

  // a transfer is taken once per strobe assertion
  assign go = stb & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= go;
      done_q <= stb & (done_q | go);
      rdat_q <= (go && !we) ? rd_regs[idx] : '0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_wen
    assign wr_en[i] = go & we & (idx == AW'(i));
  end

  assign ack  = ack_q;
  assign rdat = rdat_q;
endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~prev_q;
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cap,
  output logic         irq
);
  logic [W-1:0] cap_q, clr_now;

  assign clr_now = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= (cap_q & ~clr_now) | set_bits; // new edge beats clear
  end

  assign cap = cap_q;
  assign irq = |(cap_q & mask);
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
  import pio_pkg::*;
#(
  parameter pio_mode_e MODE = PIO_TRISTATE,
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int IO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_reg,
  input  logic [REG_W-1:0]  bus_wdat,
  output logic [REG_W-1:0]  bus_rdat,
  output logic              bus_ack,
  input  logic [IN_W-1:0]   pin_in,
  output logic [OUT_W-1:0]  pin_out,
  inout  wire  [IO_W-1:0]   pin_io,
  output logic              irq
);
  localparam bit IS_TRI  = (MODE == PIO_TRISTATE);
  localparam bit HAS_IN  = (MODE != PIO_OUT_ONLY);
  localparam bit HAS_OUT = (MODE != PIO_IN_ONLY);
  localparam int IN_BITS  = IS_TRI ? IO_W : IN_W;
  localparam int OUT_BITS = IS_TRI ? IO_W : OUT_W;
  localparam logic [REG_W-1:0] IN_MSK  = HAS_IN  ? low_mask(IN_BITS)  : '0;
  localparam logic [REG_W-1:0] OUT_MSK = HAS_OUT ? low_mask(OUT_BITS) : '0;
  localparam logic [REG_W-1:0] DIR_MSK = IS_TRI  ? low_mask(IO_W)     : '0;

  logic [N_REGS-1:0]            wr_en;
  logic [N_REGS-1:0][REG_W-1:0] rd_regs;
  logic [REG_W-1:0] dout_q, dir_q, mask_q;
  logic [REG_W-1:0] raw, level, rise, cap_q;

  pio_bus_port #(.DW(REG_W), .NREG(N_REGS), .AW(IDX_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .stb(bus_stb), .we(bus_we), .idx(bus_reg),
    .rd_regs(rd_regs), .ack(bus_ack), .rdat(bus_rdat), .wr_en(wr_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en[IDX_DATA]) dout_q <= bus_wdat & OUT_MSK;
      if (wr_en[IDX_DIR])  dir_q  <= bus_wdat & DIR_MSK;
      if (wr_en[IDX_MASK]) mask_q <= bus_wdat & IN_MSK;
    end
  end

  // pin sampling source chosen by mode
  always_comb begin
    raw = '0;
    if (IS_TRI)      raw = REG_W'(pin_io);
    else if (HAS_IN) raw = REG_W'(pin_in);
  end

  pio_in_sync #(.W(REG_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .level(level), .rise(rise)
  );

  pio_capture #(.W(REG_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .set_bits(rise & IN_MSK & ~dir_q),
    .clr_we(wr_en[IDX_CAP]), .clr_bits(bus_wdat),
    .mask(mask_q), .cap(cap_q), .irq(irq)
  );

  assign rd_regs[IDX_DATA] = HAS_IN ? (level & IN_MSK) : dout_q;
  assign rd_regs[IDX_DIR]  = dir_q;
  assign rd_regs[IDX_MASK] = mask_q;
  assign rd_regs[IDX_CAP]  = cap_q;

  if (IS_TRI) begin : g_tri
    for (genvar i = 0; i < IO_W; i++) begin : g_pin
      assign pin_io[i] = dir_q[i] ? dout_q[i] : 1'bz;
    end
    assign pin_out = '0;
  end else begin : g_sep
    assign pin_io  = 'z;
    assign pin_out = HAS_OUT ? dout_q[OUT_W-1:0] : '0;
  end
endmodule

// File: rtl/pio_edge_port_chk.sv
module pio_edge_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stb,
  input logic        ack,
  input logic [31:0] rdat,
  input logic [31:0] mask_q,
  input logic [31:0] cap_q,
  input logic        cap_wr,
  input logic        irq
);
  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_ack_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(stb));

  a_r2_no_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !ack);

  a_r3_rdat_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rdat == 32'd0));

  a_r7_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_wr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'd0) |-> !irq);
endmodule

bind pio_edge_port pio_edge_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stb(bus_stb), .ack(bus_ack), .rdat(bus_rdat),
  .mask_q(mask_q), .cap_q(cap_q), .cap_wr(wr_en[3]), .irq(irq)
);

// File: tb/pio_edge_port_tb.sv
`timescale 1ns/1ps
module pio_edge_port_tb;
  import pio_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  logic rst_n;

  // shared-bus instance
  logic stb = 0, we = 0;
  logic [1:0] ridx = 0;
  logic [31:0] wd = 0;
  wire [31:0] rd;
  wire ack, irq;
  wire [7:0] pad;
  wire [7:0] pout;

  // separate-bus instance
  logic stb2 = 0, we2 = 0;
  logic [1:0] ridx2 = 0;
  logic [31:0] wd2 = 0;
  logic [3:0] pin2 = 0;
  wire [31:0] rd2;
  wire ack2, irq2;
  wire [0:0] pad2;
  wire [5:0] pout2;

  logic [7:0] ext_m = 0, tri_m = 0, dout_m = 0, mask_m = 0, cap_m = 0, pad_prev = 0;

  for (genvar g = 0; g < 8; g++) begin : g_drv
    assign pad[g] = tri_m[g] ? 1'bz : ext_m[g];
  end

  pio_edge_port #(.MODE(PIO_TRISTATE), .IO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb), .bus_we(we), .bus_reg(ridx),
    .bus_wdat(wd), .bus_rdat(rd), .bus_ack(ack), .pin_in(8'h00),
    .pin_out(pout), .pin_io(pad), .irq(irq)
  );

  pio_edge_port #(.MODE(PIO_IN_OUT), .IN_W(4), .OUT_W(6), .IO_W(1)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .bus_stb(stb2), .bus_we(we2), .bus_reg(ridx2),
    .bus_wdat(wd2), .bus_rdat(rd2), .bus_ack(ack2), .pin_in(pin2),
    .pin_out(pout2), .pin_io(pad2), .irq(irq2)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pad_now();
    return (tri_m & dout_m) | (~tri_m & ext_m);
  endfunction

  task automatic xfer(input logic w, input logic [1:0] r, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    stb = 1; we = w; ridx = r; wd = d;
    @(negedge clk);
    q = rd;
    chk(ack == 1'b1, "R2 ack after strobe", {31'd0, ack}, 32'd1);
    stb = 0; we = 0;
    if (w) begin
      case (r)
        2'd0: dout_m = d[7:0];
        2'd1: tri_m  = d[7:0];
        2'd2: mask_m = d[7:0];
        default: cap_m = cap_m & ~d[7:0];
      endcase
    end
  endtask

  task automatic settle();
    logic [7:0] np;
    repeat (3) @(posedge clk);
    np = pad_now();
    cap_m = cap_m | (np & ~pad_prev & ~tri_m);
    pad_prev = np;
    @(negedge clk);
    chk(irq == |(cap_m & mask_m), "R8 irq level", {31'd0, irq}, {31'd0, |(cap_m & mask_m)});
  endtask

  task automatic wr(input logic [1:0] r, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, r, d, q);
    settle();
  endtask

  task automatic rdchk(input logic [1:0] r, input string tag);
    logic [31:0] q, e;
    xfer(1'b0, r, 32'd0, q);
    case (r)
      2'd0: e = {24'd0, pad_prev};
      2'd1: e = {24'd0, tri_m};
      2'd2: e = {24'd0, mask_m};
      default: e = {24'd0, cap_m};
    endcase
    chk(q == e, tag, q, e);
    settle();
  endtask

  task automatic set_ext(input logic [7:0] v);
    @(negedge clk);
    ext_m = v;
    settle();
  endtask

  task automatic xfer2(input logic w, input logic [1:0] r, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    stb2 = 1; we2 = w; ridx2 = r; wd2 = d;
    @(negedge clk);
    q = rd2;
    stb2 = 0; we2 = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] q;
    void'($urandom(32'd1234));
    rst_n = 0;
    repeat (4) @(negedge clk);
    // reset state (R3, R4)
    chk(ack == 0, "R3 reset ack", {31'd0, ack}, 0);
    chk(rd == 0, "R3 reset rdat", rd, 0);
    chk(irq == 0, "R3 reset irq", {31'd0, irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rdchk(2'd1, "R4 direction resets to input");
    rdchk(2'd2, "R4 mask resets to zero");
    chk(rd == 0, "R3 rdat idle", rd, 0);

    // R10 bits above width
    wr(2'd2, 32'hFFFF_FFFF);
    rdchk(2'd2, "R10 mask upper bits read zero");
    wr(2'd2, 32'h0);

    // R4 / R1 drive and map
    wr(2'd0, 32'h0000_00A5);
    wr(2'd1, 32'h0000_000F);
    chk(pad == 8'h05, "R4 driven pins follow data", {24'd0, pad}, 32'h05);
    rdchk(2'd1, "R1 direction register at index 1");
    set_ext(8'h30);
    rdchk(2'd0, "R5 data read shows pins");

    // R2 held strobe
    @(negedge clk);
    stb = 1; we = 0; ridx = 2'd2;
    @(negedge clk);
    chk(ack == 1, "R2 first ack", {31'd0, ack}, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ack == 0, "R2 no repeat ack while held", {31'd0, ack}, 0);
    end
    stb = 0;
    @(negedge clk);
    chk(ack == 0, "R2 no ack after drop", {31'd0, ack}, 0);
    settle();

    // R6 edge capture, R7 clearing, R8 masking
    set_ext(8'h00);
    wr(2'd3, 32'hFF);
    set_ext(8'h10);
    rdchk(2'd3, "R6 rising edge captured");
    chk(irq == 0, "R8 masked capture no irq", {31'd0, irq}, 0);
    set_ext(8'h00);
    rdchk(2'd3, "R6 falling edge no change");
    wr(2'd2, 32'h10);
    chk(irq == 1, "R8 unmasked irq", {31'd0, irq}, 1);
    wr(2'd3, 32'h00);
    rdchk(2'd3, "R7 write zero keeps capture");
    wr(2'd3, 32'h10);
    rdchk(2'd3, "R7 write one clears");
    chk(irq == 0, "R8 irq drops after clear", {31'd0, irq}, 0);
    wr(2'd2, 32'h01);
    wr(2'd0, 32'hA4);
    wr(2'd0, 32'hA5);
    rdchk(2'd3, "R6 driven pin edge ignored");

    // R9 separate buses
    xfer2(1'b1, 2'd0, 32'hFFFF_FF2A, q);
    chk(pout2 == 6'h2A, "R9 pin_out follows data", {26'd0, pout2}, 32'h2A);
    pin2 = 4'h9;
    repeat (3) @(negedge clk);
    xfer2(1'b0, 2'd0, 32'd0, q);
    chk(q == 32'h9, "R9 data read returns pin_in", q, 32'h9);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: wr(2'd0, $urandom);
        1: wr(2'd1, $urandom);
        2: wr(2'd2, $urandom);
        3: wr(2'd3, $urandom);
        4: set_ext($urandom);
        default: begin
          logic [1:0] r;
          r = 2'($urandom % 4);
          case (r)
            2'd0: rdchk(r, "R5 random data read");
            2'd1: rdchk(r, "R4 random direction read");
            2'd2: rdchk(r, "R10 random mask read");
            default: rdchk(r, "R6 R7 random capture read");
          endcase
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule